// File: doc/BRIEF.md
# Buffered Bulk-Program Flash Sequencer

This block is the device-side controller of a bulk programming mode for a NOR-style flash. After a two-write command entry, the host streams 16-bit data words over a simple bus write port. The controller gathers them into a 32-word staging buffer. When the buffer is full it programs the words one at a time into a modelled flash array. It reads each word back, compares it and re-pulses a word that does not match, up to a fixed retry limit.

The first data write of the mode fixes the start address and therefore the target block. Later data writes go to that same block while an internal pointer moves the array address forward. Further buffers can follow without a new command. A write to any address outside the start block ends the mode. The modelled cells behave like flash: a program pulse can only clear bits (new = old AND data). A word padded with 16'hFFFF therefore leaves an erased cell untouched, and a word that needs a 0 turned back to 1 can never verify.

Top module: `fbp_seq`

## Requirements
- R1: Entry takes a write whose low byte is 8'h80, followed by a write whose low byte is 8'hD0. The confirm clears status bits 7, 5, 4 and 3 to 0.
- R2: After the setup byte, any other byte returns the block to idle and sets status bit 5 (command error). In idle, a write that is not the setup byte has no effect on the array.
- R3: The first data write latches the start address. Word i of buffer k is stored at the start block with offset (start offset + 32k + i) mod 256, so the pointer wraps inside the 256-word block.
- R4: Programming begins only after the 32nd word of a buffer has been accepted. Status bit 0 (busy) reads 1 from the cycle after that write until the buffer is done.
- R5: Programming clears bits only: a cell becomes old AND data. Words padded with 16'hFFFF leave erased cells at 16'hFFFF.
- R6: Each program pulse is followed by a verify cycle. A word that verifies on the first pulse costs 2 busy cycles. A word that never verifies costs 2*(1+4) = 10 cycles, because MAX_RETRY is 4 re-pulses.
- R7: A word still mismatching after the last retry sets status bit 4 (program failure). The sequence continues, and the bit stays set until the next entry.
- R8: A data write while busy is ignored: it does not enter the buffer. It sets status bit 3 (sequence error).
- R9: After a buffer completes, a further 32-word buffer can be loaded and programmed without re-entering the command.
- R10: A write outside the start block, while loading, ends the mode: status bit 7 becomes 1, busy is 0 and the controller returns to idle. Words of a partly filled buffer are discarded.
- R11: After reset the status byte is 8'h00 and every array word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one word per cycle |
| wr_addr | input | 10 | Bus write word address |
| wr_data | input | 16 | Bus write data; low byte carries command codes |
| rd_addr | input | 10 | Array read address |
| rd_data | output | 16 | Array word at rd_addr |
| status | output | 8 | Status byte: bit 7 exited, 5 command error, 4 program failure, 3 sequence error, 0 busy |

## Verification
The hardest situation to reach from the ports is a verify mismatch that runs out of retries. Erased cells always accept any data, so a mismatch needs a cell that has already been programmed. The bench first programs one region and exits. It then re-enters with a start offset near the block end, so that the buffer wraps onto that region with data needing cleared bits set again. It predicts from old AND new which words fail, the busy cycle count and the failure flag. A write issued during programming and a partly filled buffer at exit are also driven, and a full-array sweep after each phase compares against a bench-side model.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_FIRST,
      ST_FILL,
      ST_PROG,
      ST_VERIFY
   } fbp_state_e;

   localparam int SB_BUSY = 0;
   localparam int SB_SEQ  = 3;
   localparam int SB_FAIL = 4;
   localparam int SB_CMD  = 5;
   localparam int SB_DONE = 7;

endpackage

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (we) slots[widx] <= wdata;
   end

   assign rdata = slots[ridx];

endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 10,
   parameter bit CLEAR_ONLY = 1'b1,
   localparam int WORDS     = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pg_en,
   input  logic [ADDR_W-1:0] pg_addr,
   input  logic [DATA_W-1:0] pg_data,
   input  logic [ADDR_W-1:0] vf_addr,
   output logic [DATA_W-1:0] vf_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] cells [WORDS];
   logic [DATA_W-1:0] cell_next;

   generate
      if (CLEAR_ONLY) begin : g_clear
         assign cell_next = cells[pg_addr] & pg_data;
      end else begin : g_direct
         assign cell_next = pg_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) cells[i] <= '1;
      end else if (pg_en) begin
         cells[pg_addr] <= cell_next;
      end
   end

   assign vf_data = cells[vf_addr];
   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
   import fbp_pkg::*;
#(
   parameter int          DATA_W      = 16,
   parameter int          ADDR_W      = 10,
   parameter int          BLK_W       = 8,
   parameter int          BUF_WORDS   = 32,
   parameter int          MAX_RETRY   = 4,
   parameter logic [7:0]  CMD_SETUP   = 8'h80,
   parameter logic [7:0]  CMD_CONFIRM = 8'hD0,
   localparam int         BUF_W       = $clog2(BUF_WORDS),
   localparam int         TRY_W       = $clog2(MAX_RETRY + 1),
   localparam int         TAG_W       = ADDR_W - BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        cmd_byte,
   output logic              buf_we,
   output logic [BUF_W-1:0]  buf_widx,
   output logic [BUF_W-1:0]  buf_ridx,
   input  logic [DATA_W-1:0] buf_rdata,
   output logic              pg_en,
   output logic [ADDR_W-1:0] word_addr,
   input  logic [DATA_W-1:0] vf_data,
   output logic [7:0]        status
);

   fbp_state_e       state;
   logic [TAG_W-1:0] tag;
   logic [BLK_W-1:0] offs;
   logic [BUF_W-1:0] cnt;
   logic [TRY_W-1:0] tries;
   logic             f_done, f_cmd, f_fail, f_seq;

   logic busy, in_blk, last, match, spent;

   assign busy   = (state == ST_PROG) || (state == ST_VERIFY);
   assign in_blk = (wr_addr[ADDR_W-1:BLK_W] == tag);
   assign last   = (cnt == BUF_W'(BUF_WORDS - 1));
   assign match  = (vf_data == buf_rdata);
   assign spent  = (tries == TRY_W'(MAX_RETRY));

   assign word_addr = {tag, offs + BLK_W'(cnt)};
   assign buf_we    = wr_en && ((state == ST_FIRST) || (state == ST_FILL && in_blk));
   assign buf_widx  = cnt;
   assign buf_ridx  = cnt;
   assign pg_en     = (state == ST_PROG);

   always_comb begin
      status          = '0;
      status[SB_BUSY] = busy;
      status[SB_SEQ]  = f_seq;
      status[SB_FAIL] = f_fail;
      status[SB_CMD]  = f_cmd;
      status[SB_DONE] = f_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         tag    <= '0;
         offs   <= '0;
         cnt    <= '0;
         tries  <= '0;
         f_done <= 1'b0;
         f_cmd  <= 1'b0;
         f_fail <= 1'b0;
         f_seq  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (wr_en && cmd_byte == CMD_SETUP) state <= ST_SETUP;
            end
            ST_SETUP: begin
               if (wr_en) begin
                  if (cmd_byte == CMD_CONFIRM) begin
                     f_done <= 1'b0;
                     f_cmd  <= 1'b0;
                     f_fail <= 1'b0;
                     f_seq  <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_FIRST;
                  end else begin
                     f_cmd <= 1'b1;
                     state <= ST_IDLE;
                  end
               end
            end
            ST_FIRST: begin
               if (wr_en) begin
                  tag   <= wr_addr[ADDR_W-1:BLK_W];
                  offs  <= wr_addr[BLK_W-1:0];
                  cnt   <= BUF_W'(1);
                  state <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (wr_en) begin
                  if (!in_blk) begin
                     f_done <= 1'b1;
                     cnt    <= '0;
                     state  <= ST_IDLE;
                  end else if (last) begin
                     cnt   <= '0;
                     tries <= '0;
                     state <= ST_PROG;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_PROG: begin
               if (wr_en) f_seq <= 1'b1;
               state <= ST_VERIFY;
            end
            ST_VERIFY: begin
               if (wr_en) f_seq <= 1'b1;
               if (match || spent) begin
                  if (!match) f_fail <= 1'b1;
                  tries <= '0;
                  if (last) begin
                     offs  <= offs + BLK_W'(BUF_WORDS);
                     cnt   <= '0;
                     state <= ST_FILL;
                  end else begin
                     cnt   <= cnt + 1'b1;
                     state <= ST_PROG;
                  end
               end else begin
                  tries <= tries + 1'b1;
                  state <= ST_PROG;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fbp_seq.sv
module fbp_seq #(
   parameter int         DATA_W      = 16,
   parameter int         ADDR_W      = 10,
   parameter int         BLK_WORDS   = 256,
   parameter int         BUF_WORDS   = 32,
   parameter int         MAX_RETRY   = 4,
   parameter logic [7:0] CMD_SETUP   = 8'h80,
   parameter logic [7:0] CMD_CONFIRM = 8'hD0,
   parameter bit         CLEAR_ONLY  = 1'b1,
   localparam int        BLK_W       = $clog2(BLK_WORDS),
   localparam int        BUF_W       = $clog2(BUF_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [7:0]        status
);

   initial begin : param_chk
      if ((BLK_WORDS & (BLK_WORDS - 1)) != 0 || BLK_W >= ADDR_W)
         $fatal(1, "block size must be a power of two below the array size");
      if (BUF_WORDS < 2 || BUF_WORDS > BLK_WORDS || (BUF_WORDS & (BUF_WORDS - 1)) != 0)
         $fatal(1, "buffer depth must be a power of two within one block");
      if (MAX_RETRY < 1 || DATA_W < 8)
         $fatal(1, "retry limit and data width out of range");
   end

   logic              buf_we;
   logic [BUF_W-1:0]  buf_widx, buf_ridx;
   logic [DATA_W-1:0] buf_rdata;
   logic              pg_en;
   logic [ADDR_W-1:0] word_addr;
   logic [DATA_W-1:0] vf_data;

   fbp_ctrl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUF_WORDS(BUF_WORDS),
      .MAX_RETRY(MAX_RETRY), .CMD_SETUP(CMD_SETUP), .CMD_CONFIRM(CMD_CONFIRM)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .cmd_byte(wr_data[7:0]), .buf_we(buf_we), .buf_widx(buf_widx),
      .buf_ridx(buf_ridx), .buf_rdata(buf_rdata), .pg_en(pg_en),
      .word_addr(word_addr), .vf_data(vf_data), .status(status)
   );

   fbp_wbuf #(.DATA_W(DATA_W), .DEPTH(BUF_WORDS)) u_wbuf (
      .clk(clk), .we(buf_we), .widx(buf_widx), .wdata(wr_data),
      .ridx(buf_ridx), .rdata(buf_rdata)
   );

   fbp_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR_ONLY(CLEAR_ONLY)) u_array (
      .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .pg_addr(word_addr),
      .pg_data(buf_rdata), .vf_addr(word_addr), .vf_data(vf_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

endmodule

// File: rtl/fbp_seq_chk.sv
module fbp_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       pg_en,
   input logic [7:0] status
);

   // R8
   seq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && status[0]) |=> status[3]);

   // R4
   prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_en |-> status[0]);

   // R6
   pulse_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_en |=> (!pg_en && status[0]));

   // R7
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4] && !wr_en) |=> status[4]);

   // R10
   exit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[7]) |-> !status[0]);

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && !wr_en) |=> status[7]);

endmodule

bind fbp_seq fbp_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pg_en(pg_en), .status(status)
);

// File: tb/fbp_seq_tb.sv
module fbp_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int WORDS = 1 << AW;
   localparam int NBUF = 32;
   localparam int RETRY = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [9:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [9:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [7:0]  status;

   logic [15:0] model [WORDS];
   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fbp_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 10'(a);
      wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (status[0] && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < WORDS; a++) begin
         rd_addr = 10'(a);
         #1;
         chk(rd_data == model[a], req, int'(rd_data), int'(model[a]));
      end
   endtask

   function automatic int blk_addr(input int start, input int i);
      return (start & 'h300) | ((start + i) & 'hFF);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      int n, exp_cyc, a;
      bit any_bad;
      logic [15:0] d;
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(status == 8'h00, "R11 status", int'(status), 0);
      sweep("R11 erased");

      // R2 stray and bad command bytes
      bus_wr('h040, 'h00D0);
      chk(status == 8'h00, "R2 stray confirm", int'(status), 0);
      bus_wr('h040, 'h0080);
      bus_wr('h040, 'h0055);
      chk(status == 8'h20, "R2 bad confirm", int'(status), 'h20);
      bus_wr('h040, 'h1234);
      chk(status == 8'h20, "R2 idle write", int'(status), 'h20);
      sweep("R2 idle no effect");

      // R1 entry
      bus_wr('h000, 'h0080);
      bus_wr('h000, 'h00D0);
      chk(status == 8'h00, "R1 entry clears", int'(status), 0);

      // buffer A at 0x105: R3, R4, R6
      for (int i = 0; i < NBUF; i++) begin
         d = 16'h5A00 ^ 16'(i * 'h0111);
         bus_wr('h105, int'(d));
         if (i == NBUF - 2) chk(status[0] == 1'b0, "R4 idle before last", int'(status[0]), 0);
         a = blk_addr('h105, i);
         model[a] = model[a] & d;
      end
      chk(status[0] == 1'b1, "R4 busy after 32nd", int'(status[0]), 1);
      wait_idle(n);
      chk(n == 2 * NBUF, "R6 clean buffer cycles", n, 2 * NBUF);
      chk(status == 8'h00, "R7 no failure", int'(status), 0);

      // buffer B, padded short load, plus write while busy: R5, R8, R9
      for (int i = 0; i < NBUF; i++) begin
         d = (i < 10) ? 16'(16'hA5C3 - i) : 16'hFFFF;
         bus_wr('h105, int'(d));
         a = blk_addr('h105, NBUF + i);
         model[a] = model[a] & d;
      end
      bus_wr('h105, 'h0000);
      chk(status[3] == 1'b1, "R8 busy write flagged", int'(status[3]), 1);
      wait_idle(n);

      // buffer C: ignored busy write must not shift it (R8, R9)
      for (int i = 0; i < NBUF; i++) begin
         d = 16'(i * 'h0203) ^ 16'hF0F0;
         bus_wr('h105, int'(d));
         a = blk_addr('h105, 2 * NBUF + i);
         model[a] = model[a] & d;
      end
      wait_idle(n);
      chk(n == 2 * NBUF, "R9 third buffer cycles", n, 2 * NBUF);

      // partial buffer then exit: R10
      bus_wr('h105, 'h0001);
      bus_wr('h105, 'h0002);
      bus_wr('h105, 'h0003);
      bus_wr('h300, 'h0000);
      chk(status == 8'h88, "R10 exit status", int'(status), 'h88);
      bus_wr('h105, 'h0000);
      chk(status == 8'h88, "R10 idle after exit", int'(status), 'h88);
      sweep("R3 R5 R9 R10 array");

      // re-entry and wrapping buffer over programmed cells: R1, R3, R6, R7
      bus_wr('h1F0, 'h0080);
      bus_wr('h1F0, 'h00D0);
      chk(status == 8'h00, "R1 re-entry clears", int'(status), 0);
      exp_cyc = 0;
      any_bad = 1'b0;
      for (int i = 0; i < NBUF; i++) begin
         d = 16'h3C3C ^ 16'(i * 'h1001);
         bus_wr('h1F0, int'(d));
         a = blk_addr('h1F0, i);
         if ((d & ~model[a]) != 16'h0) begin
            exp_cyc += 2 * (RETRY + 1);
            any_bad = 1'b1;
         end else begin
            exp_cyc += 2;
         end
         model[a] = model[a] & d;
      end
      wait_idle(n);
      chk(n == exp_cyc, "R6 retry cycles", n, exp_cyc);
      chk(status[4] == any_bad, "R7 failure flag", int'(status[4]), int'(any_bad));
      chk(any_bad == 1'b1, "R7 stimulus reaches mismatch", int'(any_bad), 1);
      bus_wr('h000, 'h0000);
      chk(status == {1'b1, 2'b00, any_bad, 4'h0}, "R7 R10 final status",
          int'(status), int'({1'b1, 2'b00, any_bad, 4'h0}));
      sweep("R3 R5 wrap array");

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule